// File: doc/BRIEF.md
# Codec Power-Down and Standby Controller

This block decides, for a voice codec's digital side, whether the transmit and receive channels are running and whether the serial outputs are driven. It watches the transmit and receive frame-sync inputs, an active-high power-enable input, and a toggle that flips with the transmit data clock. All of these come from outside the reference-clock domain. A channel whose frame sync stays low for a long programmable interval goes to standby on its own. When both channels are in standby, the whole device is in standby. Driving the power-enable input low overrides everything and forces power-down.

The transmit data output and its time-slot strobe share one output enable. That enable is withheld for a fixed number of frames after reset and after every release from power-down. It is also withheld while the transmit clock toggle has been quiet for longer than a loss threshold. The receive signaling output has its own enable and a force-low control. It is forced low in power-down and in whole-device standby, and it floats when only the receive channel is in standby. All intervals are parameters counted in reference-clock cycles, so the same block serves any reference frequency.

Top module: `pwr_standby_ctrl`

## Requirements
- R1: While rst_ni is low the outputs are tx_en_o=0, rx_en_o=0, tx_oe_o=0, sig_oe_o=1 and sig_low_o=1.
- R2: Within 4 reference cycles of pwr_on_i going low, the outputs become tx_en_o=0, rx_en_o=0, tx_oe_o=0, sig_oe_o=1 and sig_low_o=1. This holds whatever the frame syncs and the clock toggle do.
- R3: After reset release, tx_oe_o stays 0 for at least FRAME_CYC*HOLD_FRAMES cycles even with frame syncs and the clock toggle active. It then becomes 1 within a few further cycles.
- R4: When tx_fsync_i stays low for more than STBY_CYC cycles, tx_en_o and tx_oe_o go to 0. In the same case rx_en_o stays 1, sig_oe_o stays 1 and sig_low_o stays 0.
- R5: When rx_fsync_i stays low for more than STBY_CYC cycles while transmit frames continue, rx_en_o=0 and sig_oe_o=0. In the same case tx_en_o and tx_oe_o stay 1.
- R6: When both frame syncs stay low for more than STBY_CYC cycles, tx_en_o=0, rx_en_o=0, tx_oe_o=0, sig_oe_o=1 and sig_low_o=1.
- R7: When tx_clk_tgl_i does not change for more than CLK_LOSS_CYC cycles, tx_oe_o goes to 0 while tx_en_o stays 1. After the toggle resumes, tx_oe_o returns to 1.
- R8: A rising edge on a channel's frame sync takes that channel out of standby within 4 cycles.
- R9: Power-down overrides any standby state. After pwr_on_i returns high, the output hold of R3 restarts from zero.
- R10: Low stretches of a frame sync shorter than STBY_CYC, separated by high pulses, never cause standby, because every high level clears the inactivity count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_on_i | input | 1 | Power enable; low requests power-down |
| tx_fsync_i | input | 1 | Transmit frame sync |
| rx_fsync_i | input | 1 | Receive frame sync |
| tx_clk_tgl_i | input | 1 | Toggles with the transmit data clock |
| tx_en_o | output | 1 | Transmit channel active |
| rx_en_o | output | 1 | Receive channel active |
| tx_oe_o | output | 1 | Drive enable for transmit data and time-slot strobe |
| sig_oe_o | output | 1 | Drive enable for receive signaling output |
| sig_low_o | output | 1 | Force receive signaling output low |

## Verification
The bound assertions check the output relations on every cycle:
- the power-down response three cycles after the pin falls;
- tx_oe_o never rising before the hold interval has elapsed since the last power-down or reset;
- the signaling float occurring only in receive-only standby;
- forced-low signaling coinciding with both channels off.

The long-interval behaviours need the bench's directed scenarios, because they depend on stimulus history rather than on instantaneous relations. These are:
- entry into standby after the inactivity limit;
- the count being cleared by short frame pulses;
- exit on a new frame edge;
- clock-loss disable and recovery;
- the hold restarting after power-down.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

  typedef enum logic [2:0] {
    MODE_RUN,
    MODE_TX_STBY,
    MODE_RX_STBY,
    MODE_ALL_STBY,
    MODE_PDN
  } dev_mode_e;

  typedef struct packed {
    logic tx_en;
    logic rx_en;
    logic tx_oe;
    logic sig_oe;
    logic sig_low;
  } out_ctl_t;

  localparam out_ctl_t OUT_RESET = '{tx_en: 1'b0, rx_en: 1'b0, tx_oe: 1'b0,
                                     sig_oe: 1'b1, sig_low: 1'b1};

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= {STAGES{RST_VAL}};
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/pwr_idle_timer.sv
// Counts cycles without kick; expired_o is sticky until the next kick.
module pwr_idle_timer #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic expired_o
);

  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic          exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (kick_i) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (!exp_q) begin
      if (cnt_q == LAST) exp_q <= 1'b1;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired_o = exp_q;

endmodule

// File: rtl/pwr_mode_dec.sv
module pwr_mode_dec
  import pwr_pkg::*;
(
  input  logic      pdn_i,
  input  logic      tx_idle_i,
  input  logic      rx_idle_i,
  output dev_mode_e mode_o
);

  always_comb begin
    if (pdn_i)                        mode_o = MODE_PDN;
    else if (tx_idle_i && rx_idle_i)  mode_o = MODE_ALL_STBY;
    else if (tx_idle_i)               mode_o = MODE_TX_STBY;
    else if (rx_idle_i)               mode_o = MODE_RX_STBY;
    else                              mode_o = MODE_RUN;
  end

endmodule

// File: rtl/pwr_standby_ctrl.sv
module pwr_standby_ctrl
  import pwr_pkg::*;
#(
  parameter int unsigned STBY_CYC     = 1228800,
  parameter int unsigned FRAME_CYC    = 512,
  parameter int unsigned HOLD_FRAMES  = 4,
  parameter int unsigned CLK_LOSS_CYC = 82,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_on_i,
  input  logic tx_fsync_i,
  input  logic rx_fsync_i,
  input  logic tx_clk_tgl_i,
  output logic tx_en_o,
  output logic rx_en_o,
  output logic tx_oe_o,
  output logic sig_oe_o,
  output logic sig_low_o
);

  localparam int unsigned HOLD_CYC = FRAME_CYC * HOLD_FRAMES;
  localparam int unsigned NCH      = 2;
  localparam int unsigned NIN      = NCH + 2;

  logic [NIN-1:0] raw_in, sync_q;
  logic [NCH-1:0] fs_s, ch_idle;
  logic           pwr_on_s, tgl_s, tgl_d_q, clk_edge;
  logic           clk_lost, hold_done, pdn;
  dev_mode_e      mode;
  out_ctl_t       nxt, out_q;

  assign raw_in = {tx_clk_tgl_i, rx_fsync_i, tx_fsync_i, pwr_on_i};

  pwr_sync #(
    .WIDTH  (NIN),
    .STAGES (SYNC_STAGES),
    .RST_VAL('0)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_q)
  );

  assign pwr_on_s = sync_q[0];
  assign fs_s     = sync_q[NCH:1];
  assign tgl_s    = sync_q[NIN-1];
  assign pdn      = !pwr_on_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tgl_d_q <= 1'b0;
    else         tgl_d_q <= tgl_s;
  end

  assign clk_edge = tgl_s ^ tgl_d_q;

  // index 0: transmit, index 1: receive
  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    pwr_idle_timer #(.LIMIT(STBY_CYC)) u_fs_idle (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .kick_i   (fs_s[ch]),
      .expired_o(ch_idle[ch])
    );
  end

  pwr_idle_timer #(.LIMIT(CLK_LOSS_CYC)) u_clk_loss (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kick_i   (clk_edge),
    .expired_o(clk_lost)
  );

  // held in reset by power-down so the frame hold restarts on release
  pwr_idle_timer #(.LIMIT(HOLD_CYC)) u_out_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kick_i   (pdn),
    .expired_o(hold_done)
  );

  pwr_mode_dec u_mode (
    .pdn_i    (pdn),
    .tx_idle_i(ch_idle[0]),
    .rx_idle_i(ch_idle[1]),
    .mode_o   (mode)
  );

  always_comb begin
    nxt = OUT_RESET;
    unique case (mode)
      MODE_RUN: begin
        nxt.tx_en   = 1'b1;
        nxt.rx_en   = 1'b1;
        nxt.sig_oe  = 1'b1;
        nxt.sig_low = 1'b0;
      end
      MODE_TX_STBY: begin
        nxt.rx_en   = 1'b1;
        nxt.sig_oe  = 1'b1;
        nxt.sig_low = 1'b0;
      end
      MODE_RX_STBY: begin
        nxt.tx_en   = 1'b1;
        nxt.sig_oe  = 1'b0;
        nxt.sig_low = 1'b0;
      end
      MODE_ALL_STBY, MODE_PDN: begin
        nxt.sig_oe  = 1'b1;
        nxt.sig_low = 1'b1;
      end
      default: nxt = OUT_RESET;
    endcase
    nxt.tx_oe = nxt.tx_en && hold_done && !clk_lost;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= OUT_RESET;
    else         out_q <= nxt;
  end

  assign tx_en_o   = out_q.tx_en;
  assign rx_en_o   = out_q.rx_en;
  assign tx_oe_o   = out_q.tx_oe;
  assign sig_oe_o  = out_q.sig_oe;
  assign sig_low_o = out_q.sig_low;

endmodule

// File: rtl/pwr_standby_chk.sv
module pwr_standby_chk #(
  parameter int unsigned HOLD_CYC = 2048
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_on_i,
  input logic tx_en_o,
  input logic rx_en_o,
  input logic tx_oe_o,
  input logic sig_oe_o,
  input logic sig_low_o
);

  localparam int unsigned SW = $clog2(HOLD_CYC + 2);

  logic [2:0]    age_q;
  logic [SW-1:0] since_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      age_q   <= '0;
      since_q <= '0;
    end else begin
      if (age_q != 3'd7) age_q <= age_q + 1'b1;
      if (!pwr_on_i)                    since_q <= '0;
      else if (since_q != SW'(HOLD_CYC)) since_q <= since_q + 1'b1;
    end
  end

  a_r2_pdn_outputs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 3'd4 && !$past(pwr_on_i, 3)) |->
      (!tx_en_o && !rx_en_o && !tx_oe_o && sig_oe_o && sig_low_o));

  a_r3_hold_before_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 3'd1 && $rose(tx_oe_o)) |-> (since_q >= SW'(HOLD_CYC)));

  a_r5_float_rx_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sig_oe_o |-> (!rx_en_o && tx_en_o));

  a_r6_low_when_all_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sig_low_o |-> (sig_oe_o && !tx_en_o && !rx_en_o));

  a_r7_drive_needs_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_oe_o |-> tx_en_o);

endmodule

bind pwr_standby_ctrl pwr_standby_chk #(
  .HOLD_CYC(FRAME_CYC * HOLD_FRAMES)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pwr_on_i (pwr_on_i),
  .tx_en_o  (tx_en_o),
  .rx_en_o  (rx_en_o),
  .tx_oe_o  (tx_oe_o),
  .sig_oe_o (sig_oe_o),
  .sig_low_o(sig_low_o)
);

// File: tb/pwr_standby_ctrl_tb.sv
module pwr_standby_ctrl_tb;

  localparam int unsigned STBY  = 200;
  localparam int unsigned FRAME = 16;
  localparam int unsigned HFR   = 4;
  localparam int unsigned LOSS  = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pwr_on = 1'b1;
  logic tx_fs = 1'b0, rx_fs = 1'b0, tgl = 1'b0;
  logic tx_en, rx_en, tx_oe, sig_oe, sig_low;
  logic tx_run = 1'b1, rx_run = 1'b1, clk_run = 1'b1;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  pwr_standby_ctrl #(
    .STBY_CYC    (STBY),
    .FRAME_CYC   (FRAME),
    .HOLD_FRAMES (HFR),
    .CLK_LOSS_CYC(LOSS),
    .SYNC_STAGES (2)
  ) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .pwr_on_i    (pwr_on),
    .tx_fsync_i  (tx_fs),
    .rx_fsync_i  (rx_fs),
    .tx_clk_tgl_i(tgl),
    .tx_en_o     (tx_en),
    .rx_en_o     (rx_en),
    .tx_oe_o     (tx_oe),
    .sig_oe_o    (sig_oe),
    .sig_low_o   (sig_low)
  );

  // frame syncs: 2-cycle pulse every FRAME cycles; clock toggle every 4 cycles
  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      ph++;
      tx_fs = tx_run && ((ph % FRAME) < 2);
      rx_fs = rx_run && ((ph % FRAME) < 2);
      if (clk_run && (ph % 4) == 0) tgl = ~tgl;
    end
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    wait_cyc(3);
    chk("R1", "tx_en", tx_en, 1'b0);
    chk("R1", "rx_en", rx_en, 1'b0);
    chk("R1", "tx_oe", tx_oe, 1'b0);
    chk("R1", "sig_oe", sig_oe, 1'b1);
    chk("R1", "sig_low", sig_low, 1'b1);
    rst_ni = 1'b1;
  endtask

  task automatic t_hold;
    wait_cyc(40);
    chk("R3", "tx_en active", tx_en, 1'b1);
    chk("R3", "tx_oe held", tx_oe, 1'b0);
    wait_cyc(60);
    chk("R3", "tx_oe after hold", tx_oe, 1'b1);
    chk("R3", "sig_low", sig_low, 1'b0);
  endtask

  task automatic t_tx_stby;
    tx_run = 1'b0;
    wait_cyc(STBY - 10);
    chk("R4", "tx_en before limit", tx_en, 1'b1);
    wait_cyc(40);
    chk("R4", "tx_en", tx_en, 1'b0);
    chk("R4", "tx_oe", tx_oe, 1'b0);
    chk("R4", "rx_en", rx_en, 1'b1);
    chk("R4", "sig_oe", sig_oe, 1'b1);
    chk("R4", "sig_low", sig_low, 1'b0);
    tx_run = 1'b1;
    wait_cyc(24);
    chk("R8", "tx_en exit", tx_en, 1'b1);
    chk("R8", "tx_oe exit", tx_oe, 1'b1);
  endtask

  task automatic t_rx_stby;
    rx_run = 1'b0;
    wait_cyc(STBY + 30);
    chk("R5", "rx_en", rx_en, 1'b0);
    chk("R5", "sig_oe", sig_oe, 1'b0);
    chk("R5", "tx_en", tx_en, 1'b1);
    chk("R5", "tx_oe", tx_oe, 1'b1);
    rx_run = 1'b1;
    wait_cyc(24);
    chk("R8", "rx_en exit", rx_en, 1'b1);
    chk("R8", "sig_oe exit", sig_oe, 1'b1);
  endtask

  task automatic t_both;
    tx_run = 1'b0;
    rx_run = 1'b0;
    wait_cyc(STBY + 30);
    chk("R6", "tx_en", tx_en, 1'b0);
    chk("R6", "rx_en", rx_en, 1'b0);
    chk("R6", "tx_oe", tx_oe, 1'b0);
    chk("R6", "sig_oe", sig_oe, 1'b1);
    chk("R6", "sig_low", sig_low, 1'b1);
    tx_run = 1'b1;
    rx_run = 1'b1;
    wait_cyc(24);
    chk("R8", "both exit tx", tx_en, 1'b1);
    chk("R8", "both exit sig_low", sig_low, 1'b0);
  endtask

  task automatic t_short;
    for (int k = 0; k < 3; k++) begin
      tx_run = 1'b0;
      wait_cyc(150);
      chk("R10", "tx_en after short gap", tx_en, 1'b1);
      tx_run = 1'b1;
      wait_cyc(20);
    end
    chk("R10", "tx_oe kept", tx_oe, 1'b1);
  endtask

  task automatic t_clk_loss;
    clk_run = 1'b0;
    wait_cyc(10);
    chk("R7", "tx_oe before loss limit", tx_oe, 1'b1);
    wait_cyc(30);
    chk("R7", "tx_oe lost", tx_oe, 1'b0);
    chk("R7", "tx_en kept", tx_en, 1'b1);
    clk_run = 1'b1;
    wait_cyc(16);
    chk("R7", "tx_oe resumed", tx_oe, 1'b1);
  endtask

  task automatic t_pdn;
    tx_run = 1'b0;
    wait_cyc(STBY + 30);
    chk("R9", "tx standby first", tx_en, 1'b0);
    pwr_on = 1'b0;
    wait_cyc(4);
    chk("R2", "tx_en", tx_en, 1'b0);
    chk("R2", "rx_en", rx_en, 1'b0);
    chk("R2", "tx_oe", tx_oe, 1'b0);
    chk("R2", "sig_oe", sig_oe, 1'b1);
    chk("R2", "sig_low", sig_low, 1'b1);
    tx_run = 1'b1;
    wait_cyc(30);
    chk("R9", "pdn overrides frames tx_en", tx_en, 1'b0);
    chk("R9", "pdn overrides frames rx_en", rx_en, 1'b0);
    pwr_on = 1'b1;
    wait_cyc(20);
    chk("R9", "tx_en after release", tx_en, 1'b1);
    chk("R9", "hold restarted", tx_oe, 1'b0);
    wait_cyc(80);
    chk("R9", "tx_oe after new hold", tx_oe, 1'b1);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_hold();
    t_tx_stby();
    t_rx_stby();
    t_both();
    t_short();
    t_clk_loss();
    t_pdn();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

endmodule